// File: doc/BRIEF.md
# Ternary Match Row with Mismatch Count

This block is one row of a ternary content-addressable memory. Each of its `WIDTH` bit cells stores two bits: a care flag and a content bit. A cell whose care flag is cleared is a wildcard that matches any search bit. Both stored bits in every cell are written through a pair of pulse inputs. The "set" pulse of the pair stores 0 and the "reset" pulse stores 1.

A search word is presented with `search_valid`. Every cell compares its own bit against the search in the same cycle. One clock later the row returns three results:
- a per-cell mismatch vector,
- a match flag that is high only when no cell mismatches,
- a count of the mismatching cells.

The count is a graded measure of distance, which a flat matchline cannot give.

Sequencing is held in a two-state machine. The state `S_IDLE` means no result was produced on the last edge. The state `S_REPORT` means a fresh result sits on the outputs. Both states take the transition to `S_REPORT` when `search_valid` is high on an edge, and the transition to `S_IDLE` otherwise.

Top module: `tcam_row`

## Requirements
- R1: Each cell holds a care flag and a content bit. A care flag of 0 makes the cell a wildcard, and a care flag of 1 makes it compare its content bit.
- R2: Cell i's mismatch bit (`miss_vec[i]`) equals care AND (content XOR `search_word[i]`). A wildcard cell always reports 0.
- R3: On a clock edge, a `*_set` pulse alone drives the selected stored bit to 0, and a `*_rst` pulse alone drives it to 1. This holds for both the care flag and the content bit.
- R4: A stored bit keeps its value when its set and reset pulses are both high in the same cycle, and also when both are low.
- R5: `match` is 1 exactly when every bit of `miss_vec` is 0.
- R6: `miss_count` equals the number of 1 bits in `miss_vec`.
- R7: A search issued in the same cycle as a write compares against the stored values from before that write.
- R8: `result_valid` is high in the cycle after each cycle in which `search_valid` is high, and low otherwise. The results are registered.
- R9: Synchronous reset (`rst` high on an edge) has these effects:
  - every care flag and content bit becomes 0;
  - `result_valid`, `miss_vec` and `miss_count` become 0;
  - `match` becomes 1.
- R10: While `search_valid` is low, `miss_vec`, `match` and `miss_count` hold their previous values.
- R11: The control state machine has two states, `S_IDLE` and `S_REPORT`. It enters `S_REPORT` on an edge with `search_valid` high and `S_IDLE` on any other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| care_set | input | WIDTH | Per-cell pulse storing 0 in the care flag |
| care_rst | input | WIDTH | Per-cell pulse storing 1 in the care flag |
| data_set | input | WIDTH | Per-cell pulse storing 0 in the content bit |
| data_rst | input | WIDTH | Per-cell pulse storing 1 in the content bit |
| search_valid | input | 1 | Search request for this cycle |
| search_word | input | WIDTH | Search word, one bit per cell |
| result_valid | output | 1 | Results below are fresh this cycle |
| miss_vec | output | WIDTH | Registered per-cell mismatch bits |
| match | output | 1 | Registered whole-row match |
| miss_count | output | CNT_W | Registered number of mismatching cells |

## Verification
The bench builds the row at the default `WIDTH` of 4. This gives a `miss_count` of three bits. At this width, every one of the 16 search words can be swept against several stored patterns. That sweep includes the all-mismatch case, which drives `miss_count` to its largest value of 4. The small width also keeps the bench's behavioural model compact. It lets the bench try, cell by cell, every combination of the two pulses, including both pulses together, alongside a same-cycle search.

// File: rtl/tcam_row_pkg.sv
package tcam_row_pkg;
    typedef enum logic [0:0] {
        S_IDLE   = 1'b0,
        S_REPORT = 1'b1
    } row_state_e;
endpackage

// File: rtl/tcam_row_cell.sv
module tcam_row_cell (
    input  logic clk,
    input  logic rst,
    input  logic care_set,
    input  logic care_rst,
    input  logic data_set,
    input  logic data_rst,
    input  logic search_bit,
    output logic miss,
    output logic care_q,
    output logic data_q
);
    // set pulse stores 0, reset pulse stores 1, both or neither hold (R3, R4)
    always_ff @(posedge clk) begin
        if (rst) begin
            care_q <= 1'b0;
            data_q <= 1'b0;
        end else begin
            case ({care_set, care_rst})
                2'b10:   care_q <= 1'b0;
                2'b01:   care_q <= 1'b1;
                default: care_q <= care_q;
            endcase
            case ({data_set, data_rst})
                2'b10:   data_q <= 1'b0;
                2'b01:   data_q <= 1'b1;
                default: data_q <= data_q;
            endcase
        end
    end

    // compare uses the pre-edge stored values (R2, R7)
    always_comb miss = care_q & (data_q ^ search_bit);
endmodule

// File: rtl/tcam_row_popcount.sv
module tcam_row_popcount #(
    parameter int WIDTH = 4,
    parameter int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] bits_in,
    output logic [CNT_W-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            count = count + CNT_W'(bits_in[i]);
        end
    end
endmodule

// File: rtl/tcam_row.sv
module tcam_row
    import tcam_row_pkg::*;
#(
    parameter int WIDTH = 4,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] care_set,
    input  logic [WIDTH-1:0] care_rst,
    input  logic [WIDTH-1:0] data_set,
    input  logic [WIDTH-1:0] data_rst,
    input  logic             search_valid,
    input  logic [WIDTH-1:0] search_word,
    output logic             result_valid,
    output logic [WIDTH-1:0] miss_vec,
    output logic             match,
    output logic [CNT_W-1:0] miss_count
);
    logic [WIDTH-1:0] miss_now;
    logic [WIDTH-1:0] care_bits;
    logic [WIDTH-1:0] data_bits;
    logic [CNT_W-1:0] count_now;
    row_state_e       state_q;
    row_state_e       state_d;

    for (genvar g = 0; g < WIDTH; g++) begin : g_cell
        tcam_row_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .care_set   (care_set[g]),
            .care_rst   (care_rst[g]),
            .data_set   (data_set[g]),
            .data_rst   (data_rst[g]),
            .search_bit (search_word[g]),
            .miss       (miss_now[g]),
            .care_q     (care_bits[g]),
            .data_q     (data_bits[g])
        );
    end

    tcam_row_popcount #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_count (
        .bits_in (miss_now),
        .count   (count_now)
    );

    // next-state logic (R11)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = search_valid ? S_REPORT : S_IDLE;
            S_REPORT: state_d = search_valid ? S_REPORT : S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // output process (R5, R6, R8, R9, R10)
    always_ff @(posedge clk) begin
        if (rst) begin
            miss_vec   <= '0;
            miss_count <= '0;
            match      <= 1'b1;
        end else if (search_valid) begin
            miss_vec   <= miss_now;
            miss_count <= count_now;
            match      <= ~|miss_now;
        end
    end

    always_comb result_valid = (state_q == S_REPORT);
endmodule

// File: rtl/tcam_row_checker.sv
module tcam_row_checker #(
    parameter int WIDTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             search_valid,
    input logic             result_valid,
    input logic [WIDTH-1:0] miss_vec,
    input logic             match,
    input logic [CNT_W-1:0] miss_count
);
    p_match_zero_r5: assert property (@(posedge clk) disable iff (rst)
        match == (miss_vec == '0));

    p_count_ones_r6: assert property (@(posedge clk) disable iff (rst)
        miss_count == CNT_W'($countones(miss_vec)));

    p_valid_after_r8: assert property (@(posedge clk) disable iff (rst)
        search_valid |=> result_valid);

    p_no_valid_r8: assert property (@(posedge clk) disable iff (rst)
        !search_valid |=> !result_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !search_valid |=> ($stable(miss_vec) && $stable(match) && $stable(miss_count)));

    p_reset_r9: assert property (@(posedge clk)
        $past(rst) |-> (!result_valid && miss_vec == '0 && miss_count == '0 && match));
endmodule

bind tcam_row tcam_row_checker #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_checker (
    .clk          (clk),
    .rst          (rst),
    .search_valid (search_valid),
    .result_valid (result_valid),
    .miss_vec     (miss_vec),
    .match        (match),
    .miss_count   (miss_count)
);

// File: tb/tcam_row_bench.sv
module tcam_row_bench;
    localparam int W  = 4;
    localparam int CW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  care_set = '0, care_rst = '0, data_set = '0, data_rst = '0;
    logic          search_valid = 1'b0;
    logic [W-1:0]  search_word = '0;
    logic          result_valid;
    logic [W-1:0]  miss_vec;
    logic          match;
    logic [CW-1:0] miss_count;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    bit m_care [W];
    bit m_data [W];
    bit e_valid;
    bit e_vec  [W];
    int e_cnt;
    bit e_match;

    always #4 clk = ~clk;   // 125 MHz

    tcam_row #(.WIDTH(W)) u_tcam_row (
        .clk(clk), .rst(rst),
        .care_set(care_set), .care_rst(care_rst),
        .data_set(data_set), .data_rst(data_rst),
        .search_valid(search_valid), .search_word(search_word),
        .result_valid(result_valid), .miss_vec(miss_vec),
        .match(match), .miss_count(miss_count)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all(input string phase);
        int ev = 0;
        for (int i = 0; i < W; i++) ev |= int'(e_vec[i]) << i;
        check({"R8 result_valid ", phase}, int'(result_valid), int'(e_valid));
        check({"R2 miss_vec ", phase}, int'(miss_vec), ev);
        check({"R5 match ", phase}, int'(match), int'(e_match));
        check({"R6 miss_count ", phase}, int'(miss_count), e_cnt);
    endtask

    // drive one cycle, advance the model, check after the edge
    task automatic step(input string phase, input logic sv, input logic [W-1:0] sw,
                        input logic [W-1:0] cs, input logic [W-1:0] cr,
                        input logic [W-1:0] ds, input logic [W-1:0] dr);
        @(negedge clk);
        search_valid = sv; search_word = sw;
        care_set = cs; care_rst = cr; data_set = ds; data_rst = dr;
        e_valid = sv;
        if (sv) begin
            e_cnt = 0;
            for (int i = 0; i < W; i++) begin
                e_vec[i] = m_care[i] && (m_data[i] != sw[i]);
                e_cnt += int'(e_vec[i]);
            end
            e_match = (e_cnt == 0);
        end
        for (int i = 0; i < W; i++) begin
            if (cs[i] && !cr[i]) m_care[i] = 1'b0;
            if (cr[i] && !cs[i]) m_care[i] = 1'b1;
            if (ds[i] && !dr[i]) m_data[i] = 1'b0;
            if (dr[i] && !ds[i]) m_data[i] = 1'b1;
        end
        @(posedge clk);
        #1;
        compare_all(phase);
    endtask

    // program the row: care flags and content bits in one write cycle
    task automatic load(input string phase, input logic [W-1:0] care, input logic [W-1:0] data);
        step(phase, 1'b0, '0, ~care, care, ~data, data);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < W; i++) begin
            m_care[i] = 1'b0; m_data[i] = 1'b0; e_vec[i] = 1'b0;
        end
        e_valid = 1'b0; e_cnt = 0; e_match = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        compare_all("R9 during reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        compare_all("R9 after reset");

        // R1/R9: reset row is all wildcard, any word matches
        step("R1 wildcard row", 1'b1, 4'b1011, '0, '0, '0, '0);
        step("R1 wildcard row", 1'b1, 4'b1111, '0, '0, '0, '0);

        // R3: write all cares and content 1010, then compare
        load("R3 write", 4'b1111, 4'b1010);
        step("R3 exact", 1'b1, 4'b1010, '0, '0, '0, '0);
        step("R6 all miss", 1'b1, 4'b0101, '0, '0, '0, '0);
        step("R6 two miss", 1'b1, 4'b1001, '0, '0, '0, '0);

        // R10: results hold while idle
        step("R10 hold", 1'b0, 4'b0000, '0, '0, '0, '0);
        step("R10 hold", 1'b0, 4'b1111, '0, '0, '0, '0);

        // R4: both pulses together hold, on every bit
        step("R4 both pulses", 1'b0, '0, 4'b1111, 4'b1111, 4'b1111, 4'b1111);
        step("R4 check", 1'b1, 4'b1010, '0, '0, '0, '0);
        step("R4 check", 1'b1, 4'b0000, '0, '0, '0, '0);

        // R7: write and search together, search sees old contents
        step("R7 same cycle", 1'b1, 4'b1010, 4'b0000, 4'b0000, 4'b1010, 4'b0101);
        step("R7 new content", 1'b1, 4'b1010, '0, '0, '0, '0);
        step("R7 new content", 1'b1, 4'b0101, '0, '0, '0, '0);

        // R2: mixed wildcard cells, exhaustive sweep of search words
        load("R2 write", 4'b1001, 4'b1000);
        for (int s = 0; s < 16; s++) step("R2 sweep a", 1'b1, 4'(s), '0, '0, '0, '0);
        load("R2 write", 4'b0110, 4'b0010);
        for (int s = 0; s < 16; s++) step("R2 sweep b", 1'b1, 4'(s), '0, '0, '0, '0);
        load("R6 write", 4'b1111, 4'b0111);
        for (int s = 0; s < 16; s++) step("R6 sweep c", 1'b1, 4'(s), '0, '0, '0, '0);

        // R11: alternating and back-to-back searches
        step("R11 idle", 1'b0, '0, '0, '0, '0, '0);
        step("R11 report", 1'b1, 4'b1111, '0, '0, '0, '0);
        step("R11 idle", 1'b0, '0, '0, '0, '0, '0);
        step("R11 report", 1'b1, 4'b0000, '0, '0, '0, '0);
        step("R11 report", 1'b1, 4'b0111, '0, '0, '0, '0);

        // R3: single-pulse writes clear cares one cell at a time
        step("R3 clear care0", 1'b0, '0, 4'b0001, '0, '0, '0);
        step("R3 check", 1'b1, 4'b1000, '0, '0, '0, '0);
        step("R3 clear care3", 1'b0, '0, 4'b1000, '0, '0, '0);
        step("R3 check", 1'b1, 4'b1000, '0, '0, '0, '0);

        // R9: reset mid-run clears storage and results
        @(negedge clk);
        rst = 1'b1;
        search_valid = 1'b0;
        for (int i = 0; i < W; i++) begin
            m_care[i] = 1'b0; m_data[i] = 1'b0; e_vec[i] = 1'b0;
        end
        e_valid = 1'b0; e_cnt = 0; e_match = 1'b1;
        @(posedge clk);
        #1;
        compare_all("R9 mid reset");
        @(negedge clk);
        rst = 1'b0;
        step("R9 post reset", 1'b1, 4'b0110, '0, '0, '0, '0);

        summary();
        $finish;
    end
endmodule